// File: doc/BRIEF.md
# Serial Input Expander Read Controller

This block is the host side of a chain of parallel-in, serial-out expander registers. It uses only three lines: an active-low load strobe, a shift clock and the serial data returned by the chain. A one-cycle `start` request in the idle state begins a read. The controller holds the load strobe low to capture the expander inputs and then releases it. It then issues one shift clock per bit while sampling the serial line, and finally presents the assembled word together with a one-cycle done pulse.

The number of cascaded registers is the parameter `STAGES`, and each register holds `STAGE_BITS` bits, so one read returns 8, 16, 24 or more bits. The clock-inhibit input of every expander is assumed tied low, which means every shift clock rising edge advances the chain. The load-pulse width and both shift-clock phases come from the `div_len` input, counted in system clock cycles.

The result side is plain and has no back-pressure. `rd_word` changes only in the cycle `rd_done` is high and holds its value until the next read finishes, so a consumer may take it at the pulse or at any time before the next read completes. `start` is only accepted while idle.

Top module: `exp_reader`

## Requirements
- R1: After reset, `xp_load_n` is 1, `xp_sclk` is 0, `rd_done` is 0 and `rd_word` is 0.
- R2: A `start` sampled high while idle drives `xp_load_n` low from the next cycle, for exactly `div_len`+1 cycles. `xp_sclk` stays low while `xp_load_n` is low.
- R3: Each read produces exactly `STAGES`*`STAGE_BITS` rising edges on `xp_sclk`, and all of them come after the load strobe has returned high.
- R4: Every high phase of `xp_sclk` lasts `div_len`+1 cycles. Every low phase that precedes a rising edge, including the first one after the load strobe is released, also lasts `div_len`+1 cycles.
- R5: Each bit is taken from `xp_sdi` in the last cycle of a low phase, before the rising edge that shifts the chain. The first bit is therefore the one presented right after the load is released.
- R6: Bits enter the result MSB-first: the first sampled bit becomes `rd_word[W-1]`. For a cascade whose serial output comes from stage 0 and whose bit 7 leaves first, `rd_word` equals {stage0[7:0], stage1[7:0], ...}, the captured inputs with stage 0 in the top byte.
- R7: `rd_done` is high for exactly one cycle per read. `rd_word` takes its new value in that same cycle and stays constant in every other cycle.
- R8: A `start` that arrives while a read is in progress is ignored. It produces no second load pulse and no extra done pulse.
- R9: The word width follows `STAGES`, and reads of 8, 16 and 24 bits return the full captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Read request, accepted only while idle |
| div_len | input | DIV_W | Phase length minus one, in system cycles; held during a read |
| xp_load_n | output | 1 | Active-low load strobe to the expander chain |
| xp_sclk | output | 1 | Shift clock to the expander chain |
| xp_sdi | input | 1 | Serial data from the last expander in the chain |
| rd_done | output | 1 | One-cycle pulse marking a finished read |
| rd_word | output | STAGES*STAGE_BITS | Assembled word, MSB-first |

## Verification
The bench drives three controllers (one, two and three stages) against behavioural cascade models and sweeps all 256 values of an 8-bit seed, deriving each stage's byte arithmetically from it. A design that sampled after the rising edge would lose the top bit and shift every other bit up by one. One that issued one clock too few or too many would leave a truncated or rotated word, and the per-read edge count would be wrong. Phase widths are measured at a non-zero divider setting, where an off-by-one in the timer appears as a short or long strobe or clock phase. A second `start` in the middle of a read checks for a spurious extra load pulse or double done. The held result is checked after the done pulse, where a design that exposed its shift register would show the word moving.

// File: rtl/exp_reader_pkg.sv
package exp_reader_pkg;

  // Sequencer phases; pin levels decode directly from these.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } rd_state_e;

endpackage

// File: rtl/exp_phase_timer.sv
// Counts system cycles inside one sequencer phase; a phase lasts len+1 cycles.
module exp_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] len,
  output logic             expire
);

  logic [DIV_W-1:0] cnt_q;

  assign expire = !clear && (cnt_q == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/exp_bit_counter.sv
// Counts sampled bits within one read.
module exp_bit_counter #(
  parameter int TOTAL = 8,
  localparam int CW   = $clog2(TOTAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic all_taken
);

  logic [CW-1:0] cnt_q;

  assign all_taken = (cnt_q == CW'(TOTAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/exp_capture.sv
// MSB-first assembly register plus the held result register.
module exp_capture #(
  parameter int STAGES     = 1,
  parameter int STAGE_BITS = 8,
  localparam int W         = STAGES * STAGE_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         bit_in,
  input  logic         commit,
  output logic [W-1:0] word
);

  logic [W-1:0] shreg_q;
  logic [W-1:0] shreg_d;

  // Oldest sample moves up one place per new bit; the newest enters at bit 0.
  generate
    if (W == 1) begin : g_single
      assign shreg_d = bit_in;
    end else begin : g_multi
      assign shreg_d = {shreg_q[W-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (take) begin
      shreg_q <= shreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (commit) begin
      word <= shreg_q;
    end
  end

endmodule

// File: rtl/exp_reader.sv
module exp_reader
  import exp_reader_pkg::*;
#(
  parameter int STAGES     = 1,
  parameter int STAGE_BITS = 8,
  parameter int DIV_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [DIV_W-1:0]             div_len,
  output logic                         xp_load_n,
  output logic                         xp_sclk,
  input  logic                         xp_sdi,
  output logic                         rd_done,
  output logic [STAGES*STAGE_BITS-1:0] rd_word
);

  localparam int WORD_W = STAGES * STAGE_BITS;

  rd_state_e state_q;
  rd_state_e state_d;
  logic      phase_end;
  logic      all_taken;
  logic      take_bit;
  logic      finish;

  exp_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q == ST_IDLE),
    .len    (div_len),
    .expire (phase_end)
  );

  exp_bit_counter #(.TOTAL(WORD_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state_q == ST_IDLE),
    .step      (take_bit),
    .all_taken (all_taken)
  );

  // Sample on the last low cycle, just before the rising edge is driven.
  assign take_bit = (state_q == ST_LOW) && phase_end;
  assign finish   = (state_q == ST_HIGH) && phase_end && all_taken;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)     state_d = ST_LOAD;
      ST_LOAD: if (phase_end) state_d = ST_LOW;
      ST_LOW:  if (phase_end) state_d = ST_HIGH;
      ST_HIGH: if (phase_end) state_d = all_taken ? ST_IDLE : ST_LOW;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_done <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_done <= finish;
    end
  end

  assign xp_load_n = (state_q != ST_LOAD);
  assign xp_sclk   = (state_q == ST_HIGH);

  exp_capture #(.STAGES(STAGES), .STAGE_BITS(STAGE_BITS)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take_bit),
    .bit_in (xp_sdi),
    .commit (finish),
    .word   (rd_word)
  );

endmodule

// File: rtl/exp_reader_chk.sv
module exp_reader_chk #(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  div_len,
  input logic              xp_load_n,
  input logic              xp_sclk,
  input logic              rd_done,
  input logic [WORD_W-1:0] rd_word
);

  localparam int RW = $clog2(WORD_W + 1) + 1;

  logic [DIV_W:0] hi_cnt;
  logic [RW-1:0]  rise_cnt;
  logic           sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= xp_sclk;
      hi_cnt <= xp_sclk ? hi_cnt + 1'b1 : '0;
      if (!xp_load_n) begin
        rise_cnt <= '0;
      end else if (xp_sclk && !sclk_d) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  // R2
  load_quiet_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xp_load_n |-> !xp_sclk);

  // R4
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_d && !xp_sclk) |-> (hi_cnt == ({1'b0, div_len} + 1'b1)));

  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (rise_cnt == RW'(WORD_W)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> (rd_done || $stable(rd_word)));

  // R7
  done_idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (xp_load_n && !xp_sclk));

endmodule

bind exp_reader exp_reader_chk #(.DIV_W(DIV_W), .WORD_W(STAGES*STAGE_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_len   (div_len),
  .xp_load_n (xp_load_n),
  .xp_sclk   (xp_sclk),
  .rd_done   (rd_done),
  .rd_word   (rd_word)
);

// File: tb/exp_reader_tb.sv
`timescale 1ns/1ps
module exp_reader_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] div_len = 8'd0;

  always #2 clk = ~clk;  // 250 MHz

  logic ld1, sc1, sd1, dn1; logic [7:0]  w1;
  logic ld2, sc2, sd2, dn2; logic [15:0] w2;
  logic ld3, sc3, sd3, dn3; logic [23:0] w3;
  logic [7:0]  pin1 = '0;
  logic [15:0] pin2 = '0;
  logic [23:0] pin3 = '0;
  logic [7:0]  ch1 = '0;
  logic [15:0] ch2 = '0;
  logic [23:0] ch3 = '0;

  exp_reader #(.STAGES(1)) u_dut (.clk(clk), .rst_n(rst_n), .start(start), .div_len(div_len),
    .xp_load_n(ld1), .xp_sclk(sc1), .xp_sdi(sd1), .rd_done(dn1), .rd_word(w1));
  exp_reader #(.STAGES(2)) u_dut_s2 (.clk(clk), .rst_n(rst_n), .start(start), .div_len(div_len),
    .xp_load_n(ld2), .xp_sclk(sc2), .xp_sdi(sd2), .rd_done(dn2), .rd_word(w2));
  exp_reader #(.STAGES(3)) u_dut_s3 (.clk(clk), .rst_n(rst_n), .start(start), .div_len(div_len),
    .xp_load_n(ld3), .xp_sclk(sc3), .xp_sdi(sd3), .rd_done(dn3), .rd_word(w3));

  // Cascade models: asynchronous load, shift on the rising shift clock, stage 0 top.
  always @(posedge sc1 or negedge ld1) if (!ld1) ch1 <= pin1; else ch1 <= {ch1[6:0], 1'b0};
  always @(posedge sc2 or negedge ld2) if (!ld2) ch2 <= pin2; else ch2 <= {ch2[14:0], 1'b0};
  always @(posedge sc3 or negedge ld3) if (!ld3) ch3 <= pin3; else ch3 <= {ch3[22:0], 1'b0};
  assign sd1 = ch1[7];
  assign sd2 = ch2[15];
  assign sd3 = ch3[23];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Monitors, sampled on the falling edge.
  int dcnt1 = 0, dcnt2 = 0, dcnt3 = 0;
  logic [7:0] got1; logic [15:0] got2; logic [23:0] got3;
  int rises1 = 0, rises2 = 0, rises3 = 0;
  int lrun = 0, last_lw = 0, pulses = 0;
  int hrun = 0, hmin = 1000, hmax = 0;
  int lorun = 0, lmin = 1000, lmax = 0;
  logic p1 = 0, p2 = 0, p3 = 0;

  always @(negedge clk) begin
    cycles++;
    if (dn1) begin dcnt1++; got1 = w1; end
    if (dn2) begin dcnt2++; got2 = w2; end
    if (dn3) begin dcnt3++; got3 = w3; end
    if (sc2 && !p2) rises2++;
    if (sc3 && !p3) rises3++;
    p2 = sc2; p3 = sc3;
    if (!ld1) begin
      lrun++; hmin = 1000; hmax = 0; lmin = 1000; lmax = 0; lorun = 0;
    end else if (lrun != 0) begin
      last_lw = lrun; pulses++; lrun = 0;
    end
    if (sc1) begin
      hrun++;
      if (!p1) begin
        rises1++;
        if (lorun < lmin) lmin = lorun;
        if (lorun > lmax) lmax = lorun;
        lorun = 0;
      end
    end else begin
      if (hrun != 0) begin
        if (hrun < hmin) hmin = hrun;
        if (hrun > hmax) hmax = hrun;
        hrun = 0;
      end
      if (ld1) lorun++;
    end
    p1 = sc1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Issue a read; checks that the strobe falls in the very next cycle (R2).
  task automatic do_read();
    int c1 = dcnt1, c2 = dcnt2, c3 = dcnt3;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ld1 == 1'b0, "R2 strobe falls after start", 32'(ld1), 32'd0);
    while (dcnt1 == c1 || dcnt2 == c2 || dcnt3 == c3) @(negedge clk);
  endtask

  task automatic set_pins(input int s);
    pin1 = 8'(s);
    pin2 = {8'(s), 8'(s * 29 + 3)};
    pin3 = {8'(~s), 8'(s * 73), 8'(s ^ 8'hA5)};
  endtask

  initial begin
    int r1, r2, r3, pb, db;
    logic [23:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ld1 && !sc1 && !dn1 && w1 == 0, "R1 reset outputs s1", {ld1, sc1, dn1, w1}, {3'b100, 8'd0});
    chk(ld3 && !sc3 && !dn3 && w3 == 0, "R1 reset outputs s3", {ld3, sc3, dn3}, 32'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Timing at div_len = 3: every phase four cycles (R2, R4), edge counts (R3, R9).
    div_len = 8'd3;
    set_pins(8'h5C);
    r1 = rises1; r2 = rises2; r3 = rises3;
    do_read();
    chk(last_lw == 4, "R2 load width", 32'(last_lw), 32'd4);
    chk(hmin == 4 && hmax == 4, "R4 high width", {16'(hmin), 16'(hmax)}, {16'd4, 16'd4});
    chk(lmin == 4 && lmax == 4, "R4 low width", {16'(lmin), 16'(lmax)}, {16'd4, 16'd4});
    chk(rises1 - r1 == 8, "R3 edges 1 stage", 32'(rises1 - r1), 32'd8);
    chk(rises2 - r2 == 16, "R3 R9 edges 2 stages", 32'(rises2 - r2), 32'd16);
    chk(rises3 - r3 == 24, "R3 R9 edges 3 stages", 32'(rises3 - r3), 32'd24);
    chk(got3 == pin3, "R5 R6 word at div 3", 32'(got3), 32'(pin3));

    // R7: done lasts one cycle; the word holds afterwards.
    @(negedge clk);
    chk(dn3 == 1'b0, "R7 done one cycle", 32'(dn3), 32'd0);
    held = w3;
    repeat (10) @(negedge clk);
    chk(w3 == held, "R7 word held", 32'(w3), 32'(held));

    // R8: a second start in mid-read is ignored.
    set_pins(8'h3E);
    pb = pulses; db = dcnt1;
    fork
      do_read();
      begin repeat (8) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
    join
    repeat (60) @(negedge clk);
    chk(pulses - pb == 1, "R8 one load pulse", 32'(pulses - pb), 32'd1);
    chk(dcnt1 - db == 1, "R8 one done pulse", 32'(dcnt1 - db), 32'd1);
    chk(got1 == pin1, "R8 word intact", 32'(got1), 32'(pin1));

    // R5: several words at div_len = 2.
    div_len = 8'd2;
    for (int s = 1; s < 256; s += 51) begin
      set_pins(s);
      do_read();
      chk(got2 == pin2, "R5 word at div 2", 32'(got2), 32'(pin2));
    end

    // R6 R9: full sweep of the seed at the fastest setting.
    div_len = 8'd0;
    for (int s = 0; s < 256; s++) begin
      set_pins(s);
      do_read();
      chk(got1 == pin1, "R6 word 1 stage", 32'(got1), 32'(pin1));
      chk(got2 == pin2, "R6 R9 word 2 stages", 32'(got2), 32'(pin2));
      chk(got3 == pin3, "R6 R9 word 3 stages", 32'(got3), 32'(pin3));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule